// File: doc/BRIEF.md
# Reset Cause Combiner with Software Halt Reset

This block merges five reset causes into one system reset pulse of fixed length. The causes are an external wake-up event while the device is in standby, a low-voltage detect event, a real-time clock alarm, a watchdog timeout and a software halt request. Each cause also sets its own sticky flag, so firmware can learn after the reset what produced it. The reset pulse does not clear the flags. Firmware clears a flag by writing 1 to it, and a power-on reset clears every flag.

Software asks for a reset by writing the halt bit of the control register. The request takes effect only when two enable bits, a reset enable and a halt enable, already held 1 before that write. The register port is a single-cycle write strobe with a one-bit select and a combinational read path.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A cause sampled at a rising clock edge drives `sys_rst` high from that edge for exactly PULSE_LEN (16) cycles, provided no further cause arrives in that time.
- R2: Each cause sets its flag in the flag register (select 1). The bits are: bit 0 wake-up, bit 1 low-voltage, bit 2 RTC alarm, bit 3 watchdog, bit 4 software.
- R3: `wake_evt` counts as a cause only while `in_standby` is 1. When `in_standby` is 0, it sets no flag and starts no pulse.
- R4: A write to select 0 with bit 2 (halt) set starts a reset only if bit 0 (reset enable) and bit 1 (halt enable) were both already 1 before the write. Otherwise the halt has no effect.
- R5: A software reset sets flag bit 4 and drives `sys_rst` in the same way as any other cause.
- R6: Flags stay set through and after the reset pulse. Writing 1 to a flag bit at select 1 clears that bit, and writing 0 leaves it unchanged.
- R7: Causes that arrive in the same cycle all set their flags. A cause sets its flag even in a cycle that writes 1 to clear that same flag.
- R8: A cause that arrives while a pulse is active restarts the count, so `sys_rst` stays high for PULSE_LEN cycles after the latest cause.
- R9: While `por_n` is low, all flags and both enables are 0 and `sys_rst` is 0.
- R10: Select 0 reads the enables back at bits 1:0. The halt bit and all upper bits read 0, and upper flag-register bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wake_evt | input | 1 | External wake-up event |
| in_standby | input | 1 | Device is in standby |
| lvd_evt | input | 1 | Low-voltage detect event |
| rtc_evt | input | 1 | RTC alarm event |
| wdg_evt | input | 1 | Watchdog timeout event |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = flag register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sys_rst | output | 1 | System reset, active high |

## Verification
The bench first drives halt writes with only one of the two enables set, and also sets an enable in the same write as the halt. A design that checks the new enable values, or only one enable, would start a spurious reset. It then raises wake-up outside standby, where a design that skips the standby gate sets flag 0. It also sends a second cause partway through a pulse, where a design that ignores the restart drops `sys_rst` too early. Finally it clears a flag in the same cycle that its cause returns. A design that lets the clear win there would lose the record, and a design whose reset pulse wipes the flags would fail every flag readback taken after a pulse.

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wake_evt,
  input  logic       in_standby,
  input  logic       lvd_evt,
  input  logic       rtc_evt,
  input  logic       wdg_evt,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sys_rst
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam int NC = 5;

  logic [NC-1:0] flags;
  logic          rst_en, halt_en;
  logic [CW-1:0] cnt;

  wire           ctl_wr  = reg_wr && !reg_sel;
  wire           flag_wr = reg_wr && reg_sel;
  wire           sw_trig = ctl_wr && reg_wdata[2] && rst_en && halt_en;
  wire [NC-1:0]  cause   = {sw_trig, wdg_evt, rtc_evt, lvd_evt, wake_evt && in_standby};
  wire [NC-1:0]  clr     = flag_wr ? reg_wdata[NC-1:0] : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags   <= '0;
      rst_en  <= 1'b0;
      halt_en <= 1'b0;
      cnt     <= '0;
    end else begin
      flags <= (flags & ~clr) | cause;
      if (ctl_wr) begin
        rst_en  <= reg_wdata[0];
        halt_en <= reg_wdata[1];
      end
      if (|cause)          cnt <= CW'(PULSE_LEN);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign sys_rst   = (cnt != '0);
  assign reg_rdata = reg_sel ? {{(8-NC){1'b0}}, flags} : {6'b0, halt_en, rst_en};

  // checker-side count of cycles since the latest cause
  logic [CW:0] hi_len;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       hi_len <= '0;
    else if (|cause)  hi_len <= '0;
    else if (sys_rst) hi_len <= hi_len + 1'b1;
  end

  a_r1_pulse_start: assert property (@(posedge clk) disable iff (!por_n)
    (wdg_evt || lvd_evt || rtc_evt) |=> sys_rst);
  a_r1_pulse_len: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (hi_len == (CW+1)'(PULSE_LEN)));
  a_r2_flags_set: assert property (@(posedge clk) disable iff (!por_n)
    (|cause) |=> ((reg_sel || 1'b1) && ((flags & $past(cause)) == $past(cause))));
  a_r3_wake_gate: assert property (@(posedge clk) disable iff (!por_n)
    (!flags[0] && !(wake_evt && in_standby)) |=> !flags[0]);
  a_r4_halt_blocked: assert property (@(posedge clk) disable iff (!por_n)
    (reg_wr && !reg_sel && reg_wdata[2] && !(rst_en && halt_en) &&
     !wdg_evt && !lvd_evt && !rtc_evt && !(wake_evt && in_standby) && !sys_rst) |=> !sys_rst);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/tb_rst_cause_ctrl.sv
module tb_rst_cause_ctrl;
  logic clk = 0, por_n = 0;
  logic wake_evt = 0, in_standby = 0, lvd_evt = 0, rtc_evt = 0, wdg_evt = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sys_rst;
  int checks = 0, fails = 0, hi = 0;
  logic [4:0] m_flags = 0;
  logic m_en = 0, m_hen = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  rst_cause_ctrl #(.PULSE_LEN(16)) dut (.*);

  function automatic logic [4:0] causes();
    logic sw = reg_wr && !reg_sel && reg_wdata[2] && m_en && m_hen;
    return {sw, wdg_evt, rtc_evt, lvd_evt, wake_evt && in_standby};
  endfunction

  function automatic logic [7:0] exp_rd();
    return reg_sel ? {3'b0, m_flags} : {6'b0, m_hen, m_en};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic [4:0] c = causes();
    logic [4:0] clr = (reg_wr && reg_sel) ? reg_wdata[4:0] : 5'b0;
    logic [4:0] nf = (m_flags & ~clr) | c;
    logic ne = m_en, nh = m_hen;
    int nc = (c != 0) ? 16 : (m_cnt > 0 ? m_cnt - 1 : 0);
    if (reg_wr && !reg_sel) begin ne = reg_wdata[0]; nh = reg_wdata[1]; end
    if (!por_n) begin nf = 0; ne = 0; nh = 0; nc = 0; end
    @(posedge clk);
    m_flags = nf; m_en = ne; m_hen = nh; m_cnt = nc;
    @(negedge clk);
    wake_evt = 0; lvd_evt = 0; rtc_evt = 0; wdg_evt = 0; reg_wr = 0;
    chk({tag, " rst"}, {7'b0, sys_rst}, {7'b0, m_cnt != 0});
    chk({tag, " rd"}, reg_rdata, exp_rd());
    if (sys_rst) hi++;
  endtask

  task automatic wr(logic sel, logic [7:0] d, string tag);
    reg_wr = 1; reg_sel = sel; reg_wdata = d; cyc(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    // R9 reset state
    cyc("R9"); reg_sel = 1; cyc("R9");
    por_n = 1;
    // R1 R2 watchdog pulse length and flag bit 3
    hi = 0; wdg_evt = 1; idle(20, "R1");
    chk("R1 len", 8'(hi), 8'd16);
    chk("R2 wdg flag", reg_rdata, 8'h08);
    // R3 wake outside standby, then inside
    in_standby = 0; wake_evt = 1; hi = 0; idle(3, "R3");
    chk("R3 no pulse", 8'(hi), 8'd0);
    in_standby = 1; wake_evt = 1; idle(18, "R3"); in_standby = 0;
    // R4 halt blocked: only reset enable, then enable set in same write
    hi = 0;
    wr(0, 8'h05, "R4"); wr(0, 8'h06, "R4"); wr(0, 8'h07, "R4"); idle(2, "R4");
    chk("R4 no pulse", 8'(hi), 8'd0);
    // R10 readback
    reg_sel = 0; cyc("R10"); chk("R10 ctl", reg_rdata, 8'h03);
    // R5 software reset
    hi = 0; wr(0, 8'h07, "R5"); reg_sel = 1; idle(18, "R5");
    chk("R5 len", 8'(hi), 8'd16);
    chk("R5 flag", reg_rdata & 8'h10, 8'h10);
    // R6 clear one flag, zero writes keep
    wr(1, 8'h00, "R6"); wr(1, 8'h08, "R6"); reg_sel = 1; cyc("R6");
    chk("R6 cleared", reg_rdata & 8'h08, 8'h00);
    // R7 simultaneous causes and set beating clear
    wr(1, 8'h1F, "R7");
    lvd_evt = 1; rtc_evt = 1; reg_wr = 1; reg_sel = 1; reg_wdata = 8'h06; cyc("R7");
    chk("R7 both", reg_rdata, 8'h06);
    idle(16, "R7");
    // R8 restart mid-pulse
    hi = 0; rtc_evt = 1; idle(5, "R8"); rtc_evt = 1; idle(20, "R8");
    chk("R8 len", 8'(hi), 8'd21);
    // R9 power-on reset mid-run
    lvd_evt = 1; cyc("R9"); por_n = 0; cyc("R9"); reg_sel = 0; cyc("R9"); por_n = 1;
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      wdg_evt = (r[3:0] == 0); lvd_evt = (r[7:4] == 0); rtc_evt = (r[11:8] == 0);
      wake_evt = (r[14:12] == 0); in_standby = r[15];
      reg_wr = (r[17:16] == 0); reg_sel = r[18]; reg_wdata = r[26:19];
      if (r[31:27] == 0) por_n = 0; else por_n = 1;
      cyc("R2 R6 R7 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule